// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. A sample-clock enable runs at 16 or 8 times the bit rate and drives all of its timing. The line passes through a two-stage synchroniser and idles high. A start bit is accepted only when the line has stayed low for half a bit time. Every later bit is then sampled once per bit period, which places each sample at mid-bit.

Character length, a nine-bit override, bit order and parity handling are set by inputs. The receiver captures these settings when it accepts a start bit. Each finished character appears on a registered data output with a one-cycle valid strobe. Parity, framing and overrun flags come with the character and hold until the next character completes.

Only one stop bit is checked. The receiver goes back to hunting for a start edge as soon as it has sampled that stop bit. This lets it stay in step with a transmitter that sends characters back to back.

Top module: `uart_os_rx`

## Requirements
- R1: While `rst` is high and after it falls, `rx_valid`, `rx_data`, `par_err`, `frm_err` and `ovr_err` are all zero until a character completes.
- R2: With `os8_sel`=0 a start bit is accepted on the 8th consecutive low sample. A low pulse that lasts 7 samples or fewer produces no character, and the low-sample count restarts.
- R3: With `os8_sel`=1 a start bit is accepted on the 4th consecutive low sample, and each later bit is sampled every 8 enabled ticks. With `os8_sel`=0 the spacing is every 16 ticks.
- R4: `char_len` 0,1,2,3 selects 5,6,7,8 data bits, and `nine_bit`=1 selects 9 data bits. Data bits above the selected length read 0 on `rx_data`.
- R5: With `msb_first`=0 the first data bit received lands in `rx_data[0]`. With `msb_first`=1 it lands in `rx_data[n-1]` for an n-bit character.
- R6: `par_mode` chooses the parity handling: 000 even, 001 odd, 010 parity bit must be 0, 011 parity bit must be 1, 1xx no parity bit. When a parity bit is expected it sits between the last data bit and the stop bit, and `par_err` is 1 if it does not match the expected value.
- R7: If the sampled stop bit is 0, `frm_err` is 1 and the character is still delivered with `rx_valid`.
- R8: Only one stop bit is sampled. The next start search begins in the same cycle that `rx_valid` is raised, so a character whose start bit directly follows a single stop bit is received.
- R9: `rx_valid` is high for exactly one clock per character. `rx_data` and the three flags change only with `rx_valid` and hold their values in between.
- R10: `ovr_err` is 1 on a completed character if the previous character was not acknowledged by `rd_ack` before that cycle. An `rd_ack` in the completing cycle counts as acknowledging the previous character.
- R11: Receiver state advances only on clocks where `samp_en` is 1. With the enable high one clock in three, characters at three times the bit period are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample tick at 16x or 8x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| os8_sel | input | 1 | 0 selects 16x oversampling, 1 selects 8x |
| char_len | input | 2 | Data bits minus five (5 to 8 bits) |
| nine_bit | input | 1 | Forces nine data bits |
| msb_first | input | 1 | 1 assembles the most significant bit first |
| par_mode | input | 3 | Parity handling selection |
| rd_ack | input | 1 | Consumer has taken the current character |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| par_err | output | 1 | Parity mismatch on the last character |
| frm_err | output | 1 | Stop bit sampled low on the last character |
| ovr_err | output | 1 | Last character overwrote an unread one |

## Verification
A tick counter that is off by one shifts every sample away from mid-bit. With a whole-bit error, the data the bench reads shows shifted or repeated bits within the same character. A wrong start-qualification count turns a short low glitch into a spurious character one frame later, or makes 8x mode misread its first data bit. A state machine that lingers after the stop bit loses the next back-to-back character. This shows up as a missing strobe, or as a frame decoded from the wrong edge, within the following frame. Errors in the latched format or parity selection appear directly as wrong masked data or a wrong `par_err` on the character in which they occur.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_PAR  = 2'd2,
    ST_STOP = 2'd3
  } rx_state_e;

  // parity selection: bit 2 set disables the parity bit entirely
  localparam int PM_NONE_BIT = 2;

  function automatic logic par_expect(input logic [1:0] kind, input logic ones_odd);
    logic r;
    case (kind)
      2'd0:    r = ones_odd;      // even: total ones must be even
      2'd1:    r = ~ones_odd;     // odd
      2'd2:    r = 1'b0;          // forced low
      default: r = 1'b1;          // forced high
    endcase
    return r;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_timing.sv
module uart_rx_timing #(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic os8,
  input  logic line,
  input  logic hunt,
  output logic start_stb,
  output logic bit_stb
);
  localparam int CW = $clog2(OS_HI);
  localparam logic [CW-1:0] FULL_HI = CW'(OS_HI - 1);
  localparam logic [CW-1:0] FULL_LO = CW'(OS_LO - 1);
  localparam logic [CW-1:0] HALF_HI = CW'(OS_HI / 2 - 1);
  localparam logic [CW-1:0] HALF_LO = CW'(OS_LO / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] full_m1, half_m1;

  assign full_m1   = os8 ? FULL_LO : FULL_HI;
  assign half_m1   = os8 ? HALF_LO : HALF_HI;
  assign start_stb = samp_en && hunt && !line && (cnt_q == half_m1);
  assign bit_stb   = samp_en && !hunt && (cnt_q == full_m1);

  // one counter serves both start qualification and bit spacing
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (samp_en) begin
      if (hunt) begin
        if (line || start_stb) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end else begin
        if (bit_stb) cnt_q <= '0;
        else         cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int MAXW = 9,
  localparam int IW = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line,
  input  logic            start_stb,
  input  logic            bit_stb,
  input  logic [IW-1:0]   nbits_in,
  input  logic            msbf_in,
  input  logic [2:0]      pmode_in,
  output logic            hunt,
  output logic            done,
  output logic [MAXW-1:0] data,
  output logic            par_bad
);
  rx_state_e      st_q;
  logic [IW-1:0]  idx_q, nb_q, pos;
  logic           msbf_q, par_q;
  logic [2:0]     pm_q;
  logic [MAXW-1:0] data_q;

  assign pos = msbf_q ? (nb_q - 1'b1 - idx_q) : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HUNT;
      idx_q  <= '0;
      nb_q   <= IW'(MAXW - 1);
      msbf_q <= 1'b0;
      pm_q   <= 3'b100;
      par_q  <= 1'b0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_HUNT: if (start_stb) begin
          st_q   <= ST_DATA;
          idx_q  <= '0;
          data_q <= '0;
          nb_q   <= nbits_in;
          msbf_q <= msbf_in;
          pm_q   <= pmode_in;
        end
        ST_DATA: if (bit_stb) begin
          for (int i = 0; i < MAXW; i++)
            if (pos == IW'(i)) data_q[i] <= line;
          idx_q <= idx_q + 1'b1;
          if (idx_q == nb_q - 1'b1)
            st_q <= pm_q[PM_NONE_BIT] ? ST_STOP : ST_PAR;
        end
        ST_PAR: if (bit_stb) begin
          par_q <= line;
          st_q  <= ST_STOP;
        end
        default: if (bit_stb) st_q <= ST_HUNT;
      endcase
    end
  end

  assign hunt    = (st_q == ST_HUNT);
  assign done    = (st_q == ST_STOP) && bit_stb;
  assign data    = data_q;
  assign par_bad = !pm_q[PM_NONE_BIT] && (par_q != par_expect(pm_q[1:0], ^data_q));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OS_HI     = 16,
  parameter int OS_LO     = 8,
  parameter int SYNC_STG  = 2,
  parameter int MAXW      = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            samp_en,
  input  logic            rxd,
  input  logic            os8_sel,
  input  logic [1:0]      char_len,
  input  logic            nine_bit,
  input  logic            msb_first,
  input  logic [2:0]      par_mode,
  input  logic            rd_ack,
  output logic [MAXW-1:0] rx_data,
  output logic            rx_valid,
  output logic            par_err,
  output logic            frm_err,
  output logic            ovr_err
);
  localparam int IW = $clog2(MAXW + 1);

  logic line, hunt, start_stb, bit_stb, done, par_bad, pend_q;
  logic [IW-1:0]   nbits;
  logic [MAXW-1:0] fdata;

  assign nbits = nine_bit ? IW'(MAXW) : IW'(5) + IW'(char_len);

  uart_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line)
  );

  uart_rx_timing #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_timing (
    .clk(clk), .rst(rst), .samp_en(samp_en), .os8(os8_sel), .line(line),
    .hunt(hunt), .start_stb(start_stb), .bit_stb(bit_stb)
  );

  uart_rx_frame #(.MAXW(MAXW)) u_frame (
    .clk(clk), .rst(rst), .line(line), .start_stb(start_stb), .bit_stb(bit_stb),
    .nbits_in(nbits), .msbf_in(msb_first), .pmode_in(par_mode),
    .hunt(hunt), .done(done), .data(fdata), .par_bad(par_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      rx_valid <= done;
      if (done) begin
        rx_data <= fdata;
        par_err <= par_bad;
        frm_err <= !line;
        ovr_err <= pend_q && !rd_ack;
        pend_q  <= 1'b1;
      end else if (rd_ack) begin
        pend_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int MAXW = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            samp_en,
  input logic            line,
  input logic            hunt,
  input logic            rx_valid,
  input logic [MAXW-1:0] rx_data,
  input logic            ovr_err
);
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));

  p_idle_without_tick_r11: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> $stable(hunt));

  p_start_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(hunt) |-> !$past(line));

  p_rearm_at_stop_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> hunt);

  p_overrun_with_char_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_err) |-> rx_valid);
endmodule

bind uart_os_rx uart_os_rx_chk #(.MAXW(MAXW)) u_chk (
  .clk(clk), .rst(rst), .samp_en(samp_en), .line(line), .hunt(hunt),
  .rx_valid(rx_valid), .rx_data(rx_data), .ovr_err(ovr_err)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;
  logic clk = 1'b0, rst = 1'b1, samp_en = 1'b1, rxd = 1'b1;
  logic os8_sel = 1'b0, nine_bit = 1'b0, msb_first = 1'b0, rd_ack = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic [2:0] par_mode = 3'b100;
  logic [8:0] rx_data;
  logic rx_valid, par_err, frm_err, ovr_err;

  int n_chk = 0, n_fail = 0;
  int bitclk = 16, ediv = 1, ecnt = 0;

  always #2.5 clk = ~clk;

  uart_os_rx u0 (
    .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd), .os8_sel(os8_sel),
    .char_len(char_len), .nine_bit(nine_bit), .msb_first(msb_first),
    .par_mode(par_mode), .rd_ack(rd_ack), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  always @(negedge clk) begin
    if (ecnt >= ediv - 1) begin ecnt <= 0; samp_en <= 1'b1; end
    else begin ecnt <= ecnt + 1; samp_en <= 1'b0; end
  end

  int cap_n = 0, dbl = 0;
  logic [8:0] cap_d = '0;
  logic cap_p = 0, cap_f = 0, cap_o = 0, prev_v = 0;
  always @(negedge clk) begin
    if (rx_valid) begin
      cap_n = cap_n + 1; cap_d = rx_data;
      cap_p = par_err; cap_f = frm_err; cap_o = ovr_err;
    end
    if (rx_valid && prev_v) dbl = dbl + 1;
    prev_v = rx_valid;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bitout(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic set_cfg(input bit o8, input bit nine, input int clen, input bit msbf,
                         input logic [2:0] pm, input int div);
    os8_sel = o8; nine_bit = nine; char_len = 2'(clen); msb_first = msbf;
    par_mode = pm; ediv = div; bitclk = (o8 ? 8 : 16) * div;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v, input int nb, input bit flip,
                      input bit bad_stop, input int post);
    logic ones = 1'b0;
    logic pb;
    bitout(1'b0, bitclk);
    for (int i = 0; i < nb; i++) begin
      logic b;
      b = msb_first ? v[nb-1-i] : v[i];
      ones ^= b;
      bitout(b, bitclk);
    end
    if (!par_mode[2]) begin
      case (par_mode[1:0])
        2'd0: pb = ones;
        2'd1: pb = ~ones;
        2'd2: pb = 1'b0;
        default: pb = 1'b1;
      endcase
      bitout(pb ^ flip, bitclk);
    end
    if (bad_stop) begin
      bitout(1'b0, bitclk * 3 / 4);
      bitout(1'b1, bitclk - bitclk * 3 / 4);
    end else begin
      bitout(1'b1, bitclk);
    end
    bitout(1'b1, post);
  endtask

  task automatic expect_char(input string req, input int n0, input int exp_d,
                             input bit p, input bit f, input bit o);
    chk(req, "count", cap_n, n0 + 1);
    chk(req, "data", int'(cap_d), exp_d);
    chk(req, "par_err", int'(cap_p), int'(p));
    chk(req, "frm_err", int'(cap_f), int'(f));
    chk(req, "ovr_err", int'(cap_o), int'(o));
  endtask

  task automatic t_reset();
    chk("R1", "valid in reset", int'(rx_valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "valid", int'(rx_valid), 0);
    chk("R1", "data", int'(rx_data), 0);
    chk("R1", "flags", int'({par_err, frm_err, ovr_err}), 0);
  endtask

  task automatic t_basic_and_glitch();
    int n0;
    set_cfg(0, 0, 3, 0, 3'b000, 1);
    n0 = cap_n; send(9'h0A5, 8, 0, 0, 16); expect_char("R2", n0, 'hA5, 0, 0, 0); ack();
    n0 = cap_n; bitout(1'b0, 7); bitout(1'b1, 60);
    chk("R2", "glitch of 7 ignored", cap_n, n0);
    n0 = cap_n; send(9'h03C, 8, 0, 0, 16); expect_char("R2", n0, 'h3C, 0, 0, 0); ack();
  endtask

  task automatic t_lengths();
    int n0;
    for (int c = 0; c < 3; c++) begin
      set_cfg(0, 0, c, 0, 3'b100, 1);
      n0 = cap_n; send(9'h1F5, 5 + c, 0, 0, 16);
      expect_char("R4", n0, 'h1F5 & ((1 << (5 + c)) - 1), 0, 0, 0); ack();
    end
    set_cfg(0, 1, 0, 0, 3'b001, 1);
    n0 = cap_n; send(9'h1A5, 9, 0, 0, 16); expect_char("R4", n0, 'h1A5, 0, 0, 0); ack();
  endtask

  task automatic t_msb();
    int n0;
    set_cfg(0, 0, 3, 1, 3'b100, 1);
    n0 = cap_n; send(9'h04E, 8, 0, 0, 16); expect_char("R5", n0, 'h4E, 0, 0, 0); ack();
    set_cfg(0, 0, 1, 1, 3'b100, 1);
    n0 = cap_n; send(9'h021, 6, 0, 0, 16); expect_char("R5", n0, 'h21, 0, 0, 0); ack();
  endtask

  task automatic t_parity();
    int n0;
    set_cfg(0, 0, 3, 0, 3'b001, 1);
    n0 = cap_n; send(9'h0B7, 8, 0, 0, 16); expect_char("R6", n0, 'hB7, 0, 0, 0); ack();
    set_cfg(0, 0, 3, 0, 3'b000, 1);
    n0 = cap_n; send(9'h0B7, 8, 1, 0, 16); expect_char("R6", n0, 'hB7, 1, 0, 0); ack();
    repeat (20) @(negedge clk);
    chk("R9", "par_err held", int'(par_err), 1);
    set_cfg(0, 0, 3, 0, 3'b011, 1);
    n0 = cap_n; send(9'h012, 8, 0, 0, 16); expect_char("R6", n0, 'h12, 0, 0, 0); ack();
    set_cfg(0, 0, 3, 0, 3'b010, 1);
    n0 = cap_n; send(9'h012, 8, 1, 0, 16); expect_char("R6", n0, 'h12, 1, 0, 0); ack();
  endtask

  task automatic t_framing();
    int n0;
    set_cfg(0, 0, 3, 0, 3'b100, 1);
    n0 = cap_n; send(9'h066, 8, 0, 1, 40); expect_char("R7", n0, 'h66, 0, 1, 0); ack();
    n0 = cap_n; send(9'h099, 8, 0, 0, 16); expect_char("R7", n0, 'h99, 0, 0, 0); ack();
  endtask

  task automatic t_back_to_back();
    int n0;
    set_cfg(0, 0, 3, 0, 3'b000, 1);
    n0 = cap_n; send(9'h0C3, 8, 0, 0, 0); expect_char("R8", n0, 'hC3, 0, 0, 0);
    n0 = cap_n; send(9'h05A, 8, 0, 0, 0); expect_char("R8", n0, 'h5A, 0, 0, 1);
    ack();
    n0 = cap_n; send(9'h0E1, 8, 0, 0, 32); expect_char("R8", n0, 'hE1, 0, 0, 0); ack();
  endtask

  task automatic t_os8();
    int n0;
    set_cfg(1, 0, 3, 0, 3'b001, 1);
    n0 = cap_n; bitout(1'b0, 3); bitout(1'b1, 40);
    chk("R3", "glitch of 3 ignored", cap_n, n0);
    n0 = cap_n; send(9'h0D4, 8, 0, 0, 8); expect_char("R3", n0, 'hD4, 0, 0, 0); ack();
    n0 = cap_n; send(9'h02B, 8, 0, 0, 8); expect_char("R3", n0, 'h2B, 0, 0, 0); ack();
  endtask

  task automatic t_gated();
    int n0;
    set_cfg(0, 0, 2, 0, 3'b000, 3);
    n0 = cap_n; send(9'h055, 7, 0, 0, 48); expect_char("R11", n0, 'h55, 0, 0, 0); ack();
    set_cfg(0, 0, 3, 0, 3'b100, 1);
  endtask

  task automatic t_overrun();
    int n0;
    n0 = cap_n; send(9'h011, 8, 0, 0, 16); expect_char("R10", n0, 'h11, 0, 0, 0);
    n0 = cap_n; send(9'h022, 8, 0, 0, 16); expect_char("R10", n0, 'h22, 0, 0, 1);
    ack();
    n0 = cap_n; send(9'h033, 8, 0, 0, 16); expect_char("R10", n0, 'h33, 0, 0, 0); ack();
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    repeat (20) @(negedge clk);
    t_basic_and_glitch();
    t_lengths();
    t_msb();
    t_parity();
    t_framing();
    t_back_to_back();
    t_os8();
    t_gated();
    t_overrun();
    chk("R9", "multi-cycle valid pulses", dbl, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule